// File: doc/BRIEF.md
# Top-of-Book Order Tracker

This block keeps a small on-chip table of resting orders for a single instrument, together with a running summary of the book: the highest bid price seen, the lowest ask price seen, and the total resting quantity on each side. A command stream delivers two kinds of work. An add places an order, made of an identifier, a price, a quantity and a side, into a table slot. An execute takes a filled quantity off an order that is already resting.

Each order goes into the slot given by its identifier modulo the table size. A later add to the same slot overwrites the earlier entry. The best prices only move on adds. The bid can only rise and the ask can only fall; executes never pull them back. Remaining quantities and side totals clamp at zero rather than wrapping.

Commands use a valid/ready handshake. A command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. The block then holds `cmd_ready` low for exactly one cycle while it reads and rewrites the slot. It raises `done` for one cycle on the following edge, which is also when the summary outputs change. An upstream source that keeps `cmd_valid` high with stable fields simply waits. At most one command is taken every two cycles.

Top module: `order_book_tracker`

## Requirements
- R1: After reset, `best_bid` is 0, `best_ask` is all ones, `bid_total` and `ask_total` are 0, `done` is low, `cmd_ready` is high, and every table slot is empty.
- R2: A command accepted on edge k drives `cmd_ready` low after edge k. `done` pulses high for exactly the cycle after edge k+1, and `cmd_ready` is high again at that point. A command held on a low `cmd_ready` is taken exactly once.
- R3: The slot index is the order identifier modulo the slot count (64 by default). An add overwrites its slot. After an add, an execute naming the earlier identifier of that slot is refused.
- R4: An add with `cmd_side` = 0 (buy) raises `best_bid` to its price only when that price is strictly higher. A lower or equal buy price leaves `best_bid` unchanged.
- R5: An add with `cmd_side` = 1 (sell) lowers `best_ask` to its price only when that price is strictly lower. A higher or equal sell price leaves `best_ask` unchanged.
- R6: An add increases the total of its own side by its quantity and reports `done_status` = 1, `done_remaining` equal to the quantity, and `done_price` equal to the price.
- R7: An execute on a matching slot reduces the remaining quantity by the executed amount, clamping at 0. It reports status 2 (filled) when the prior remaining quantity was not greater than the executed amount, and otherwise keeps the prior status. `done_remaining` gives the new remaining quantity and `done_price` gives the stored price.
- R8: An execute on a matching slot subtracts the executed amount from the total of the side stored with the order, clamping at 0. The command's `cmd_side` is ignored.
- R9: An execute whose slot is empty (status 0) or holds a different identifier changes neither the table nor the totals. It reports `done_err` = 1 with `done_status`, `done_remaining` and `done_price` all 0.
- R10: Executes never change `best_bid` or `best_ask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_op | input | 1 | 0 = add, 1 = execute |
| cmd_oid | input | OID_W (64) | Order identifier |
| cmd_price | input | PX_W (64) | Limit price (add only) |
| cmd_qty | input | QTY_W (32) | Order size for add, filled amount for execute |
| cmd_side | input | 1 | 0 = buy, 1 = sell (add only) |
| done | output | 1 | One-cycle pulse per finished command |
| done_err | output | 1 | Execute refused, valid with done |
| done_status | output | 2 | Resulting slot status: 0 empty, 1 new, 2 filled |
| done_remaining | output | QTY_W (32) | Resulting remaining quantity |
| done_price | output | PX_W (64) | Price of the order touched |
| best_bid | output | PX_W (64) | Highest buy price added |
| best_ask | output | PX_W (64) | Lowest sell price added |
| bid_total | output | QTY_W+log2(N_SLOTS) (38) | Resting buy quantity |
| ask_total | output | QTY_W+log2(N_SLOTS) (38) | Resting sell quantity |

## Verification
A corrupted slot shows up at the ports on the next execute that reaches that slot, one cycle after the handshake. It appears either as a wrong `done_remaining` or status, or as a refusal (`done_err`) where a match was due. The bench therefore follows every add with executes on the same identifier and on aliasing identifiers. A wrong side bit or a mishandled clamp shows on `bid_total` or `ask_total` in the very cycle `done` rises. Best-price errors are permanent, because the ratchets never recover. A single wrong compare stays visible until the next reset, so the bench checks both summaries after every command.

// File: rtl/obt_pkg.sv
package obt_pkg;
  typedef enum logic {
    OP_ADD  = 1'b0,
    OP_EXEC = 1'b1
  } op_e;

  typedef enum logic {
    SIDE_BUY  = 1'b0,
    SIDE_SELL = 1'b1
  } side_e;

  typedef enum logic [1:0] {
    ST_EMPTY  = 2'd0,
    ST_NEW    = 2'd1,
    ST_FILLED = 2'd2
  } st_e;
endpackage

// File: rtl/obt_slot_table.sv
module obt_slot_table #(
  parameter int N_SLOTS = 64,
  parameter int OID_W   = 64,
  parameter int PX_W    = 64,
  parameter int QTY_W   = 32,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [OID_W-1:0] rd_oid,
  output logic [PX_W-1:0]  rd_px,
  output logic [QTY_W-1:0] rd_rem,
  output logic             rd_side,
  output logic [1:0]       rd_status,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [OID_W-1:0] wr_oid,
  input  logic [PX_W-1:0]  wr_px,
  input  logic [QTY_W-1:0] wr_rem,
  input  logic             wr_side,
  input  logic [1:0]       wr_status
);
  logic [OID_W-1:0] oid_q  [N_SLOTS];
  logic [PX_W-1:0]  px_q   [N_SLOTS];
  logic [QTY_W-1:0] rem_q  [N_SLOTS];
  logic             side_q [N_SLOTS];
  logic [1:0]       st_q   [N_SLOTS];

  // payload fields need no reset: status gates every use of them
  always_ff @(posedge clk) begin
    if (wr_en) begin
      oid_q[wr_idx]  <= wr_oid;
      px_q[wr_idx]   <= wr_px;
      rem_q[wr_idx]  <= wr_rem;
      side_q[wr_idx] <= wr_side;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOTS; i++) st_q[i] <= 2'd0;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_status;
    end
  end

  assign rd_oid    = oid_q[rd_idx];
  assign rd_px     = px_q[rd_idx];
  assign rd_rem    = rem_q[rd_idx];
  assign rd_side   = side_q[rd_idx];
  assign rd_status = st_q[rd_idx];

  // R3: a write lands in the addressed slot and is visible on the next read of it
  a_r3_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (oid_q[$past(wr_idx)] == $past(wr_oid)) && (st_q[$past(wr_idx)] == $past(wr_status)));
endmodule

// File: rtl/obt_best_px.sv
module obt_best_px #(
  parameter int PX_W      = 64,
  parameter bit KEEP_HIGH = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [PX_W-1:0] px,
  output logic [PX_W-1:0] best
);
  localparam logic [PX_W-1:0] START = KEEP_HIGH ? '0 : '1;

  logic better;

  generate
    if (KEEP_HIGH) begin : g_high
      assign better = px > best;
      // R4: the bid only ever rises
      a_r4_bid_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
        best >= $past(best));
    end else begin : g_low
      assign better = px < best;
      // R5: the ask only ever falls
      a_r5_ask_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        best <= $past(best));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                best <= START;
    else if (upd_en && better) best <= px;
  end
endmodule

// File: rtl/obt_side_total.sv
module obt_side_total #(
  parameter int QTY_W = 32,
  parameter int TOT_W = 38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic             dec_en,
  input  logic [QTY_W-1:0] amt,
  output logic [TOT_W-1:0] total
);
  localparam logic [TOT_W-1:0] TOP = '1;

  logic [TOT_W-1:0] amt_w;
  logic [TOT_W-1:0] headroom;

  assign amt_w    = TOT_W'(amt);
  assign headroom = TOP - total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
    end else if (inc_en) begin
      total <= (amt_w > headroom) ? TOP : total + amt_w;
    end else if (dec_en) begin
      total <= (amt_w > total) ? '0 : total - amt_w;
    end
  end

  // R6: an add never makes a side total smaller
  a_r6_add_grows: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |=> total >= $past(total));
  // R8: an execute never makes a side total larger (no wrap below zero)
  a_r8_exec_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !inc_en) |=> total <= $past(total));
endmodule

// File: rtl/order_book_tracker.sv
module order_book_tracker #(
  parameter int N_SLOTS = 64,
  parameter int OID_W   = 64,
  parameter int PX_W    = 64,
  parameter int QTY_W   = 32,
  localparam int IDX_W  = $clog2(N_SLOTS),
  localparam int TOT_W  = QTY_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_op,
  input  logic [OID_W-1:0] cmd_oid,
  input  logic [PX_W-1:0]  cmd_price,
  input  logic [QTY_W-1:0] cmd_qty,
  input  logic             cmd_side,
  output logic             done,
  output logic             done_err,
  output logic [1:0]       done_status,
  output logic [QTY_W-1:0] done_remaining,
  output logic [PX_W-1:0]  done_price,
  output logic [PX_W-1:0]  best_bid,
  output logic [PX_W-1:0]  best_ask,
  output logic [TOT_W-1:0] bid_total,
  output logic [TOT_W-1:0] ask_total
);
  import obt_pkg::*;

  localparam bit PWR2 = (N_SLOTS & (N_SLOTS - 1)) == 0;

  // ---------------- command capture ----------------
  logic             busy;
  op_e              c_op;
  logic [OID_W-1:0] c_oid;
  logic [PX_W-1:0]  c_px;
  logic [QTY_W-1:0] c_qty;
  logic             c_side;
  logic [IDX_W-1:0] c_idx;
  logic [IDX_W-1:0] in_idx;
  logic             accept;

  generate
    if (PWR2) begin : g_idx_mask
      assign in_idx = cmd_oid[IDX_W-1:0];
    end else begin : g_idx_mod
      assign in_idx = IDX_W'(cmd_oid % OID_W'(N_SLOTS));
    end
  endgenerate

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      c_op   <= op_e'(cmd_op);
      c_oid  <= cmd_oid;
      c_px   <= cmd_price;
      c_qty  <= cmd_qty;
      c_side <= cmd_side;
      c_idx  <= in_idx;
    end
  end

  // ---------------- slot read / modify / write ----------------
  logic [OID_W-1:0] rd_oid;
  logic [PX_W-1:0]  rd_px;
  logic [QTY_W-1:0] rd_rem;
  logic             rd_side;
  logic [1:0]       rd_status;

  logic             is_add, is_exec, hit, exec_ok, filled;
  logic [QTY_W-1:0] rem_left;
  logic             wr_en;
  logic [OID_W-1:0] wr_oid;
  logic [PX_W-1:0]  wr_px;
  logic [QTY_W-1:0] wr_rem;
  logic             wr_side;
  logic [1:0]       wr_status;

  assign is_add   = busy && (c_op == OP_ADD);
  assign is_exec  = busy && (c_op == OP_EXEC);
  assign hit      = (rd_status != ST_EMPTY) && (rd_oid == c_oid);
  assign exec_ok  = is_exec && hit;
  assign filled   = rd_rem <= c_qty;
  assign rem_left = filled ? '0 : rd_rem - c_qty;

  always_comb begin
    wr_en     = is_add || exec_ok;
    wr_oid    = c_oid;
    wr_px     = c_px;
    wr_rem    = c_qty;
    wr_side   = c_side;
    wr_status = ST_NEW;
    if (!is_add) begin
      wr_px     = rd_px;
      wr_rem    = rem_left;
      wr_side   = rd_side;
      wr_status = filled ? ST_FILLED : rd_status;
    end
  end

  obt_slot_table #(
    .N_SLOTS(N_SLOTS), .OID_W(OID_W), .PX_W(PX_W), .QTY_W(QTY_W), .IDX_W(IDX_W)
  ) i_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (c_idx),
    .rd_oid   (rd_oid),
    .rd_px    (rd_px),
    .rd_rem   (rd_rem),
    .rd_side  (rd_side),
    .rd_status(rd_status),
    .wr_en    (wr_en),
    .wr_idx   (c_idx),
    .wr_oid   (wr_oid),
    .wr_px    (wr_px),
    .wr_rem   (wr_rem),
    .wr_side  (wr_side),
    .wr_status(wr_status)
  );

  // ---------------- per-side summary ----------------
  logic [PX_W-1:0]  best_q [2];
  logic [TOT_W-1:0] tot_q  [2];

  generate
    for (genvar s = 0; s < 2; s++) begin : g_side
      logic add_here, exec_here;
      assign add_here  = is_add  && (c_side  == 1'(s));
      assign exec_here = exec_ok && (rd_side == 1'(s));

      obt_best_px #(.PX_W(PX_W), .KEEP_HIGH(s == 0)) i_best (
        .clk   (clk),
        .rst_n (rst_n),
        .upd_en(add_here),
        .px    (c_px),
        .best  (best_q[s])
      );

      obt_side_total #(.QTY_W(QTY_W), .TOT_W(TOT_W)) i_total (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_en(add_here),
        .dec_en(exec_here),
        .amt   (c_qty),
        .total (tot_q[s])
      );
    end
  endgenerate

  assign best_bid  = best_q[SIDE_BUY];
  assign best_ask  = best_q[SIDE_SELL];
  assign bid_total = tot_q[SIDE_BUY];
  assign ask_total = tot_q[SIDE_SELL];

  // ---------------- completion report ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done           <= 1'b0;
      done_err       <= 1'b0;
      done_status    <= ST_EMPTY;
      done_remaining <= '0;
      done_price     <= '0;
    end else begin
      done     <= busy;
      done_err <= is_exec && !hit;
      if (wr_en) begin
        done_status    <= wr_status;
        done_remaining <= wr_rem;
        done_price     <= wr_px;
      end else begin
        done_status    <= ST_EMPTY;
        done_remaining <= '0;
        done_price     <= '0;
      end
    end
  end

  // R2: ready drops for the cycle after a handshake
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);
  // R2: done follows one cycle after the busy cycle
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 done);
  // R2: done is a single-cycle pulse
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: a filled report always carries zero remaining
  a_r7_filled_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err && done_status == ST_FILLED) |-> done_remaining == '0);
  // R9: a refused execute leaves both totals untouched
  a_r9_refused_keeps_totals: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> (bid_total == $past(bid_total)) && (ask_total == $past(ask_total)));
  // R10: executes do not move the best prices
  a_r10_exec_keeps_best: assert property (@(posedge clk) disable iff (!rst_n)
    is_exec |=> (best_bid == $past(best_bid)) && (best_ask == $past(best_ask)));
endmodule

// File: tb/test_order_book_tracker.sv
`timescale 1ns/1ps
module test_order_book_tracker;
  localparam int N = 64;
  localparam int TW = 38;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_op = 1'b0, cmd_side = 1'b0;
  logic [63:0] cmd_oid = '0, cmd_price = '0;
  logic [31:0] cmd_qty = '0;
  logic cmd_ready, done, done_err;
  logic [1:0] done_status;
  logic [31:0] done_remaining;
  logic [63:0] done_price, best_bid, best_ask;
  logic [TW-1:0] bid_total, ask_total;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  order_book_tracker i_order_book_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_oid(cmd_oid), .cmd_price(cmd_price), .cmd_qty(cmd_qty),
    .cmd_side(cmd_side), .done(done), .done_err(done_err), .done_status(done_status),
    .done_remaining(done_remaining), .done_price(done_price), .best_bid(best_bid),
    .best_ask(best_ask), .bid_total(bid_total), .ask_total(ask_total)
  );

  // expected-state model built from the requirements
  logic [63:0] m_oid [N];
  logic [63:0] m_px  [N];
  logic [31:0] m_rem [N];
  logic        m_sd  [N];
  logic [1:0]  m_st  [N];
  logic [63:0] m_bid, m_ask;
  logic [TW-1:0] m_tot [2];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_st[i] = 2'd0;
    m_bid = '0;
    m_ask = '1;
    m_tot[0] = '0;
    m_tot[1] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic cmp_summary(input string req);
    chk(best_bid == m_bid, {req, " best_bid"}, best_bid, m_bid);
    chk(best_ask == m_ask, {req, " best_ask"}, best_ask, m_ask);
    chk(bid_total == m_tot[0], {req, " bid_total"}, 64'(bid_total), 64'(m_tot[0]));
    chk(ask_total == m_tot[1], {req, " ask_total"}, 64'(ask_total), 64'(m_tot[1]));
  endtask

  // apply one command to the model; returns expected report
  task automatic model_apply(input logic op, input logic [63:0] oid, px, input logic [31:0] q,
                             input logic sd, output logic e_err, output logic [1:0] e_st,
                             output logic [31:0] e_rem, output logic [63:0] e_px);
    int idx = int'(oid % 64'(N));
    logic [31:0] prior;
    if (op == 1'b0) begin
      m_oid[idx] = oid; m_px[idx] = px; m_rem[idx] = q; m_sd[idx] = sd; m_st[idx] = 2'd1;
      if (sd == 1'b0 && px > m_bid) m_bid = px;
      if (sd == 1'b1 && px < m_ask) m_ask = px;
      m_tot[sd] = m_tot[sd] + TW'(q);
      e_err = 0; e_st = 2'd1; e_rem = q; e_px = px;
    end else if (m_st[idx] != 2'd0 && m_oid[idx] == oid) begin
      prior = m_rem[idx];
      m_rem[idx] = (prior > q) ? prior - q : 32'd0;
      if (prior <= q) m_st[idx] = 2'd2;
      m_tot[m_sd[idx]] = (TW'(q) > m_tot[m_sd[idx]]) ? '0 : m_tot[m_sd[idx]] - TW'(q);
      e_err = 0; e_st = m_st[idx]; e_rem = m_rem[idx]; e_px = m_px[idx];
    end else begin
      e_err = 1; e_st = 2'd0; e_rem = '0; e_px = '0;
    end
  endtask

  task automatic drive(input logic op, input logic [63:0] oid, px, input logic [31:0] q, input logic sd);
    cmd_valid = 1'b1; cmd_op = op; cmd_oid = oid; cmd_price = px; cmd_qty = q; cmd_side = sd;
  endtask

  task automatic check_done(input string req, input logic e_err, input logic [1:0] e_st,
                            input logic [31:0] e_rem, input logic [63:0] e_px);
    chk(done == 1'b1, "R2 done pulse", 64'(done), 64'd1);
    chk(cmd_ready == 1'b1, "R2 ready back", 64'(cmd_ready), 64'd1);
    chk(done_err == e_err, {req, " done_err"}, 64'(done_err), 64'(e_err));
    chk(done_status == e_st, {req, " done_status"}, 64'(done_status), 64'(e_st));
    chk(done_remaining == e_rem, {req, " done_remaining"}, 64'(done_remaining), 64'(e_rem));
    chk(done_price == e_px, {req, " done_price"}, done_price, e_px);
    cmp_summary(req);
  endtask

  task automatic send(input string req, input logic op, input logic [63:0] oid, px,
                      input logic [31:0] q, input logic sd);
    logic e_err; logic [1:0] e_st; logic [31:0] e_rem; logic [63:0] e_px;
    @(negedge clk);
    drive(op, oid, px, q, sd);
    chk(cmd_ready == 1'b1, "R2 ready idle", 64'(cmd_ready), 64'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R2 ready low", 64'(cmd_ready), 64'd0);
    chk(done == 1'b0, "R2 done not early", 64'(done), 64'd0);
    @(negedge clk);
    model_apply(op, oid, px, q, sd, e_err, e_st, e_rem, e_px);
    check_done(req, e_err, e_st, e_rem, e_px);
  endtask

  task automatic t_reset();
    do_reset();
    chk(best_bid == 64'd0, "R1 best_bid", best_bid, 64'd0);
    chk(best_ask == '1, "R1 best_ask", best_ask, '1);
    chk(bid_total == '0 && ask_total == '0, "R1 totals", 64'(bid_total | ask_total), 64'd0);
    chk(done == 1'b0 && cmd_ready == 1'b1, "R1 handshake idle", {62'd0, done, cmd_ready}, 64'd1);
  endtask

  task automatic t_adds();
    send("R4 R6 first buy", 0, 64'd1, 64'd100, 32'd10, 0);
    send("R4 lower buy", 0, 64'd2, 64'd90, 32'd5, 0);
    send("R4 equal buy", 0, 64'd7, 64'd100, 32'd1, 0);
    send("R4 higher buy", 0, 64'd3, 64'd150, 32'd7, 0);
    send("R5 R6 first sell", 0, 64'd4, 64'd200, 32'd8, 1);
    send("R5 higher sell", 0, 64'd5, 64'd250, 32'd3, 1);
    send("R5 lower sell", 0, 64'd6, 64'd180, 32'd2, 1);
    chk(best_bid == 64'd150, "R4 bid literal", best_bid, 64'd150);
    chk(best_ask == 64'd180, "R5 ask literal", best_ask, 64'd180);
    chk(bid_total == TW'(23), "R6 bid sum", 64'(bid_total), 64'd23);
    chk(ask_total == TW'(13), "R6 ask sum", 64'(ask_total), 64'd13);
  endtask

  task automatic t_execs();
    send("R7 partial", 1, 64'd1, 64'd0, 32'd4, 1);
    chk(done_remaining == 32'd6 && done_status == 2'd1, "R7 partial literal", 64'(done_remaining), 64'd6);
    send("R7 exact fill", 1, 64'd1, 64'd0, 32'd6, 0);
    chk(done_status == 2'd2, "R7 filled literal", 64'(done_status), 64'd2);
    send("R7 R8 overfill", 1, 64'd3, 64'd0, 32'd100, 1);
    chk(bid_total == '0, "R8 clamp at zero", 64'(bid_total), 64'd0);
    send("R8 sell side", 1, 64'd4, 64'd0, 32'd3, 0);
    chk(ask_total == TW'(10), "R8 stored side used", 64'(ask_total), 64'd10);
    chk(best_bid == 64'd150 && best_ask == 64'd180, "R10 best unchanged", best_bid, 64'd150);
  endtask

  task automatic t_refused();
    send("R9 wrong id", 1, 64'd65, 64'd0, 32'd1, 0);
    send("R9 empty slot", 1, 64'd40, 64'd0, 32'd1, 0);
    chk(done_err == 1'b1, "R9 err literal", 64'(done_err), 64'd1);
    send("R9 slot kept", 1, 64'd2, 64'd0, 32'd1, 0);
    chk(done_remaining == 32'd4, "R9 slot untouched", 64'(done_remaining), 64'd4);
  endtask

  task automatic t_alias();
    send("R3 overwrite", 0, 64'd69, 64'd50, 32'd9, 0);
    send("R3 old id refused", 1, 64'd5, 64'd0, 32'd1, 1);
    chk(done_err == 1'b1, "R3 alias err", 64'(done_err), 64'd1);
    send("R3 R8 new id", 1, 64'd69, 64'd0, 32'd1, 1);
    chk(done_remaining == 32'd8 && done_price == 64'd50, "R3 new id hit", 64'(done_remaining), 64'd8);
  endtask

  task automatic t_backpressure();
    logic e_err; logic [1:0] e_st; logic [31:0] e_rem; logic [63:0] e_px;
    @(negedge clk);
    drive(0, 64'd10, 64'd120, 32'd11, 0);
    @(negedge clk);
    drive(0, 64'd11, 64'd170, 32'd4, 1);
    chk(cmd_ready == 1'b0, "R2 held by busy", 64'(cmd_ready), 64'd0);
    @(negedge clk);
    model_apply(0, 64'd10, 64'd120, 32'd11, 0, e_err, e_st, e_rem, e_px);
    check_done("R2 first of pair", e_err, e_st, e_rem, e_px);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(done == 1'b0, "R2 gap", 64'(done), 64'd0);
    @(negedge clk);
    model_apply(0, 64'd11, 64'd170, 32'd4, 1, e_err, e_st, e_rem, e_px);
    check_done("R2 second of pair once", e_err, e_st, e_rem, e_px);
    @(negedge clk);
    chk(done == 1'b0, "R2 no repeat", 64'(done), 64'd0);
    cmp_summary("R2 single take");
  endtask

  task automatic t_clamp_and_reset();
    t_reset();
    send("R6 small sell", 0, 64'd130, 64'd77, 32'd10, 1);
    send("R7 R8 exec beyond total", 1, 64'd130, 64'd0, 32'd50, 0);
    chk(ask_total == '0 && done_status == 2'd2, "R8 sell clamp", 64'(ask_total), 64'd0);
    t_reset();
    send("R1 table cleared", 1, 64'd130, 64'd0, 32'd1, 0);
    chk(done_err == 1'b1, "R1 slot empty after reset", 64'(done_err), 64'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    t_reset();
    t_adds();
    t_execs();
    t_refused();
    t_alias();
    t_backpressure();
    t_clamp_and_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule